// File: doc/BRIEF.md
# Calibrated Multichannel DAC Code Register Bank

This block holds the digital state for a bank of DAC channels. A single parallel write port carries a channel address, a 2-bit register select and a data word. Depending on the select code, the word lands in one of three registers of the addressed channel. The input register holds the requested code. The offset register holds a signed correction, stored with a midscale bias. The gain register holds a fractional scale. The fourth select code reaches an auxiliary register space that this block does not implement, so writes that use it change nothing here.

Every channel computes a corrected code from its three registers. The corrected code is `clamp(((m + 1) * x1) >> (DW-1) + c - 2^(DW-1))`, limited to the range 0 to 2^DW - 1. A second register per channel drives the converter. Those output registers change only while the active-low load strobe is asserted, and then all channels update on the same clock edge. Software can therefore stage new codes in any order, and every output moves at once.

Top module: `dac_bank`

## Requirements
- R1: After reset, every output code is 0. Every gain register holds all ones (DW-1 bits) and every offset register holds 2^(DW-1), so a channel loaded without calibration writes reproduces its input code.
- R2: A write with select 2'b11 to a channel address below NCH stores the data word in that channel's input register.
- R3: A write with select 2'b10 to a channel address below NCH stores the data word in that channel's offset register. Offset 2^(DW-1) means zero correction.
- R4: A write with select 2'b01 to a channel address below NCH stores data bits [DW-1:1] in that channel's gain register. Data bit 0 is discarded.
- R5: The corrected code of a channel is ((m+1)*x1 >> (DW-1)) + c - 2^(DW-1), saturated to 0 below and to 2^DW - 1 above.
- R6: While load_n is high, the output codes keep their values, whatever writes occur.
- R7: On every rising clock edge at which load_n is low, every channel's output code takes that channel's corrected code as it stood before the edge. All channels update on the same edge.
- R8: A write to a channel address of NCH or above changes no register.
- R9: A write with select 2'b00 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | AW (6) | Channel address |
| wr_sel | input | 2 | Register select: 11 input, 10 offset, 01 gain, 00 auxiliary |
| wr_data | input | DW (14) | Write data |
| load_n | input | 1 | Active-low simultaneous load strobe |
| dac_out | output | NCH*DW (560) | Output codes, channel i in bits [i*DW +: DW] |

## Verification
The bench builds the bank with NCH=5, DW=6 and AW=3. At that size the gain field is 5 bits and codes are 6 bits. This makes it cheap to sweep every gain value against every input code at several offsets, including both saturation limits. The 3-bit address also leaves three unmapped addresses, so the rejection of out-of-range writes can be exercised. A five-channel bank is small enough to check every output after each load, which shows that staged writes stay invisible until the strobe and that all channels then move on the same edge.

// File: rtl/dac_bank.sv
module dac_bank #(
  parameter int NCH = 40,
  parameter int DW  = 14,
  parameter int AW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [1:0]        wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic              load_n,
  output logic [NCH*DW-1:0] dac_out
);
  localparam int PW   = 2 * DW;
  localparam int HALF = 1 << (DW - 1);
  localparam int MAXV = (1 << DW) - 1;

  logic [NCH-1:0][DW-1:0] x1_q;
  logic [NCH-1:0][DW-1:0] c_q;
  logic [NCH-1:0][DW-2:0] m_q;
  logic [NCH-1:0][DW-1:0] corr;
  logic [NCH-1:0][DW-1:0] dac_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic                 hit;
    logic [PW-1:0]        prod;
    logic [DW:0]          scaled;
    logic signed [DW+1:0] sum;

    assign hit    = wr_en && (wr_addr == AW'(i));
    assign prod   = PW'({1'b0, m_q[i]} + DW'(1)) * PW'(x1_q[i]);
    assign scaled = prod[PW-1:DW-1];
    assign sum    = $signed({1'b0, scaled}) + $signed({2'b00, c_q[i]})
                  - $signed((DW+2)'(HALF));

    always_comb begin
      if (sum < 0)                             corr[i] = '0;
      else if (sum > $signed((DW+2)'(MAXV)))   corr[i] = '1;
      else                                     corr[i] = sum[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        x1_q[i] <= '0;
        c_q[i]  <= DW'(HALF);
        m_q[i]  <= '1;
      end else if (hit) begin
        case (wr_sel)
          2'b11:   x1_q[i] <= wr_data;
          2'b10:   c_q[i]  <= wr_data;
          2'b01:   m_q[i]  <= wr_data[DW-1:1];
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dac_q[i] <= '0;
      else if (!load_n) dac_q[i] <= corr[i];
    end
  end

  assign dac_out = dac_q;
endmodule

// File: rtl/dac_bank_chk.sv
module dac_bank_chk #(
  parameter int NCH = 40,
  parameter int DW  = 14,
  parameter int AW  = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [AW-1:0]          wr_addr,
  input logic [1:0]             wr_sel,
  input logic [DW-1:0]          wr_data,
  input logic                   load_n,
  input logic [NCH*DW-1:0]      dac_out,
  input logic [NCH-1:0][DW-1:0] x1_q,
  input logic [NCH-1:0][DW-1:0] c_q,
  input logic [NCH-1:0][DW-2:0] m_q,
  input logic [NCH-1:0][DW-1:0] corr
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> $stable(dac_out));

  assert_load_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (dac_out == $past(corr)));

  assert_far_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_addr) >= NCH)) |=> ($stable(x1_q) && $stable(c_q) && $stable(m_q)));

  assert_aux_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'b00) |=> ($stable(x1_q) && $stable(c_q) && $stable(m_q)));

  assert_gain_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'b01 && wr_addr == '0) |=> (m_q[0] == $past(wr_data[DW-1:1])));
endmodule

bind dac_bank dac_bank_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_sel(wr_sel),
  .wr_data(wr_data), .load_n(load_n), .dac_out(dac_out),
  .x1_q(x1_q), .c_q(c_q), .m_q(m_q), .corr(corr)
);

// File: tb/dac_bank_test.sv
module dac_bank_test;
  localparam int NCH = 5;
  localparam int DW  = 6;
  localparam int AW  = 3;
  localparam int HALF = 1 << (DW - 1);
  localparam int MAXV = (1 << DW) - 1;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              wr_en = 0;
  logic [AW-1:0]     wr_addr = '0;
  logic [1:0]        wr_sel = '0;
  logic [DW-1:0]     wr_data = '0;
  logic              load_n = 1;
  logic [NCH*DW-1:0] dac_out;

  int checks = 0;
  int errors = 0;
  int ex1 [NCH];
  int ec  [NCH];
  int em  [NCH];
  int edac[NCH];

  always #2.5 clk = ~clk;

  dac_bank #(.NCH(NCH), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_sel(wr_sel), .wr_data(wr_data), .load_n(load_n), .dac_out(dac_out)
  );

  function automatic int model(int m, int c, int x);
    int v;
    v = (((m + 1) * x) >> (DW - 1)) + c - HALF;
    if (v < 0) v = 0;
    if (v > MAXV) v = MAXV;
    return v;
  endfunction

  task automatic wr(int a, int s, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_sel = 2'(s); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 0;
    if (a < NCH) begin
      if (s == 3) ex1[a] = d;
      if (s == 2) ec[a]  = d;
      if (s == 1) em[a]  = d >> 1;
    end
  endtask

  task automatic load();
    @(negedge clk);
    load_n = 0;
    @(negedge clk);
    load_n = 1;
    for (int i = 0; i < NCH; i++) edac[i] = model(em[i], ec[i], ex1[i]);
  endtask

  task automatic chk_ch(int i, string tag);
    int got;
    got = int'(dac_out[i*DW +: DW]);
    checks++;
    if (got !== edac[i]) begin
      errors++;
      $display("FAIL %s ch%0d got %0d expected %0d", tag, i, got, edac[i]);
    end
  endtask

  task automatic chk_all(string tag);
    for (int i = 0; i < NCH; i++) chk_ch(i, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      ex1[i] = 0; ec[i] = HALF; em[i] = HALF - 1; edac[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_all("R1 reset outputs");

    // R1 default calibration is unity; R2 input writes; R6 staged writes invisible
    for (int i = 0; i < NCH; i++) wr(i, 3, 10 * i + 7);
    chk_all("R6 no load after input writes");
    load();
    chk_all("R1 R2 R7 default calibration load");

    // R8 out-of-range and R9 aux select leave registers alone
    for (int a = NCH; a < (1 << AW); a++) begin
      wr(a, 3, 1); wr(a, 2, 0); wr(a, 1, 0);
    end
    for (int i = 0; i < NCH; i++) begin
      wr(i, 0, 0);
    end
    load();
    chk_all("R8 R9 ignored writes");

    // R7 simultaneous update of all channels with one load
    for (int i = 0; i < NCH; i++) wr(i, 3, MAXV - 3 * i);
    for (int i = 0; i < NCH; i++) wr(i, 2, HALF + i);
    chk_all("R6 staged offsets invisible");
    load();
    chk_all("R3 R7 single load updates all");

    // R7 continuous follow while strobe held low, R6 hold after release
    @(negedge clk);
    load_n = 0;
    wr(2, 3, 20);
    chk_ch(2, "R7 one edge latency old value");
    @(negedge clk);
    edac[2] = model(em[2], ec[2], ex1[2]);
    chk_ch(2, "R7 follows while held low");
    load_n = 1;
    wr(2, 3, 50);
    repeat (3) @(negedge clk);
    chk_ch(2, "R6 hold after release");

    // R5 saturation corners
    wr(0, 1, 63); wr(0, 2, 63); wr(0, 3, 63);
    wr(1, 2, 0);  wr(1, 3, 0);
    load();
    chk_ch(0, "R5 high clamp");
    chk_ch(1, "R5 low clamp");

    // R4 R5 sweep: all gains, all input codes, several offsets; data bit 0 set and dropped
    for (int m = 0; m < HALF; m++) begin
      for (int cs = 0; cs < 4; cs++) begin
        int ch;
        ch = (m + cs) % NCH;
        wr(ch, 1, (m << 1) | 1);
        wr(ch, 2, cs * 21);
        for (int x = 0; x <= MAXV; x++) begin
          wr(ch, 3, x);
          load();
          chk_ch(ch, "R4 R5 sweep");
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule